// File: doc/BRIEF.md
# SDRAM Open-Row Command Sequencer

This block sits between a requester that issues single read or write accesses and an SDRAM command bus. Each access names a bank, a row and a column. The block turns it into the right series of activate, column, precharge and refresh commands, and keeps every gap between commands at or above a programmable minimum.

A configuration bit selects one of two policies. In the closing policy, every column command carries auto-precharge, so the bank closes by itself. In the open policy, column commands leave the bank open. A per-bank table then remembers the open row, so a later access to that row skips activation. An access to another row in that bank precharges it first.

A free-running refresh timer forces periodic auto-refresh. Before a refresh, any open bank is closed with a precharge-all command. As a result, no bank stays active longer than the programmed refresh interval.

Top module: `sdram_row_sequencer`

## Requirements
- R1: Under synchronous reset the command output holds NOP, `req_ready` is low and every bank is marked closed, so the first access to any bank after reset begins with an activate.
- R2: `cmd_code` uses this encoding: 0 NOP, 1 activate, 2 read, 3 write, 4 read with auto-precharge, 5 write with auto-precharge, 6 precharge one bank, 7 precharge all banks, 8 auto-refresh. No other value appears.
- R3: An access to a closed bank issues activate (bank on `cmd_bank`, row on `cmd_addr`) and then the column command (column zero-extended on `cmd_addr`), with no precharge.
- R4: With `cfg_keep_open` = 0, column commands are codes 4/5 and the bank is closed afterwards, so a repeat access to the same row activates again.
- R5: With `cfg_keep_open` = 1, column commands are codes 2/3 and the row stays open. A later access to that bank and row issues only the column command, and each bank keeps its own row.
- R6: With `cfg_keep_open` = 1, an access to a different row in an open bank issues precharge for that bank, then activate with the new row, then the column command.
- R7: The 2-bit fields `cfg_t_pre`, `cfg_t_rcd` and `cfg_t_wr` encode v+1 cycles (1 to 4). Precharge is followed by activate exactly t_pre cycles later, and activate by the column command exactly t_rcd cycles later.
- R8: After a write with auto-precharge, no command is issued for t_wr + t_pre cycles. After a read with auto-precharge, or after a refresh, the next command comes no earlier than t_pre cycles later.
- R9: A precharge or precharge-all that follows a plain write comes no earlier than t_wr cycles after it.
- R10: `req_ready` is high for exactly the one cycle in which the access's column command is on `cmd_code`. The request is consumed in that cycle and must be held unchanged until then. No new request is started while `req_ready` is high, so back-to-back row hits are two cycles apart.
- R11: With `cfg_ref_interval` = N > 0, a refresh falls due every N cycles and refresh commands issued from idle are exactly N cycles apart. N = 0 disables refresh.
- R12: A due refresh with banks open issues precharge-all, then auto-refresh exactly t_pre later, and leaves all banks closed. With no bank open, auto-refresh is issued directly.
- R13: When a refresh is due and a request is waiting in the same idle cycle, the refresh is issued first.
- R14: Every cycle that issues no command drives NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_keep_open | input | 1 | 1 = leave banks open, 0 = auto-precharge every access |
| cfg_t_pre | input | 2 | Precharge time, value v means v+1 cycles |
| cfg_t_rcd | input | 2 | Activate-to-column delay, v+1 cycles |
| cfg_t_wr | input | 2 | Write recovery time, v+1 cycles |
| cfg_ref_interval | input | REF_W | Refresh period in cycles, 0 disables |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_ready | output | 1 | Access consumed; column command issued this cycle |
| cmd_code | output | 4 | Command code (R2 encoding) |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ROW_W | Row for activate, column for column commands |

## Verification
On every cycle, the bound checker confirms four things. Activate never follows a precharge too early, and column commands never follow activate too early. After a write with auto-precharge the bus stays silent, and a precharge waits out write recovery. It also checks that the command type always matches the selected policy, and that `req_ready` pulses only together with a column command. Several behaviours can only be shown by the bench's scenarios over all 64 timing settings: which sequence a hit, a miss or a closed bank produces, that each bank keeps its own row, and the exact refresh period. The same holds for refresh taking priority over a waiting request and for every bank being closed after a refresh.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_RDA  = 4'd4,
    CMD_WRA  = 4'd5,
    CMD_PRE  = 4'd6,
    CMD_PALL = 4'd7,
    CMD_REF  = 4'd8
  } sdram_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_RW   = 2'd2,
    ST_REF  = 2'd3
  } seq_state_e;

  // A 2-bit timing field v stands for v+1 cycles.
  function automatic logic [3:0] field_cycles(input logic [1:0] f);
    return {2'b00, f} + 4'd1;
  endfunction

endpackage

// File: rtl/open_row_table.sv
module open_row_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  output logic              look_open,
  output logic              look_hit,
  output logic              any_open,
  input  logic              set_en,
  input  logic [BANK_W-1:0] set_bank,
  input  logic [ROW_W-1:0]  set_row,
  input  logic              clr_en,
  input  logic [BANK_W-1:0] clr_bank,
  input  logic              clr_all
);

  logic [NUM_BANKS-1:0] valid_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[b] <= 1'b0;
      end else if (clr_all || (clr_en && clr_bank == BANK_W'(b))) begin
        valid_q[b] <= 1'b0;
      end else if (set_en && set_bank == BANK_W'(b)) begin
        valid_q[b] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (set_en && set_bank == BANK_W'(b)) begin
        row_q[b] <= set_row;
      end
    end
  end

  always_comb begin
    look_open = valid_q[look_bank];
    look_hit  = valid_q[look_bank] && (row_q[look_bank] == look_row);
    any_open  = |valid_q;
  end

endmodule

// File: rtl/cmd_spacing_timer.sv
module cmd_spacing_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gap_load,
  input  logic [CW-1:0] gap_cycles,
  input  logic          wr_load,
  input  logic [CW-1:0] wr_cycles,
  output logic          gap_free,
  output logic          wr_free
);

  logic [CW-1:0] load_val [2];
  logic [1:0]    load_en;
  logic [1:0]    is_zero;

  assign load_en  = {wr_load, gap_load};
  assign load_val[0] = gap_cycles;
  assign load_val[1] = wr_cycles;

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
      end else if (load_en[i]) begin
        cnt_q <= load_val[i] - CW'(1);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
    assign is_zero[i] = (cnt_q == '0);
  end

  assign gap_free = is_zero[0];
  assign wr_free  = is_zero[1];

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REF_W-1:0] interval,
  input  logic             ack,
  output logic             pending
);

  logic [REF_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else if (interval == '0) begin
      cnt_q <= '0;
      if (ack) pending <= 1'b0;
    end else if (cnt_q >= interval - REF_W'(1)) begin
      cnt_q   <= '0;
      pending <= 1'b1;
    end else begin
      cnt_q <= cnt_q + REF_W'(1);
      if (ack) pending <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_row_sequencer.sv
module sdram_row_sequencer
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int REF_W     = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CW       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_keep_open,
  input  logic [1:0]        cfg_t_pre,
  input  logic [1:0]        cfg_t_rcd,
  input  logic [1:0]        cfg_t_wr,
  input  logic [REF_W-1:0]  cfg_ref_interval,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  output logic [3:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_addr
);

  seq_state_e  state_q, state_d;
  sdram_cmd_e  cmd_q, issue;
  logic [BANK_W-1:0] iss_bank;
  logic [ROW_W-1:0]  iss_addr;
  logic [CW-1:0]     gap_cyc;
  logic [CW-1:0]     t_pre, t_rcd, t_wr;
  logic gap_free, wr_free, wr_load;
  logic look_open, look_hit, any_open;
  logic set_en, clr_en, clr_all;
  logic ref_pend, ref_ack, rdy_d, do_act, do_rw;
  sdram_cmd_e rw_cmd;
  logic [CW-1:0] rw_gap;

  assign t_pre = field_cycles(cfg_t_pre);
  assign t_rcd = field_cycles(cfg_t_rcd);
  assign t_wr  = field_cycles(cfg_t_wr);

  open_row_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst(rst),
    .look_bank(req_bank), .look_row(req_row),
    .look_open(look_open), .look_hit(look_hit), .any_open(any_open),
    .set_en(set_en), .set_bank(req_bank), .set_row(req_row),
    .clr_en(clr_en), .clr_bank(req_bank), .clr_all(clr_all)
  );

  cmd_spacing_timer #(.CW(CW)) u_space (
    .clk(clk), .rst(rst),
    .gap_load(issue != CMD_NOP), .gap_cycles(gap_cyc),
    .wr_load(wr_load), .wr_cycles(t_wr),
    .gap_free(gap_free), .wr_free(wr_free)
  );

  refresh_timer #(.REF_W(REF_W)) u_ref (
    .clk(clk), .rst(rst),
    .interval(cfg_ref_interval), .ack(ref_ack), .pending(ref_pend)
  );

  // Column command and the silence that follows it, per policy.
  always_comb begin
    if (cfg_keep_open) begin
      rw_cmd = req_write ? CMD_WR : CMD_RD;
      rw_gap = CW'(1);
    end else begin
      rw_cmd = req_write ? CMD_WRA : CMD_RDA;
      rw_gap = req_write ? (t_wr + t_pre) : t_pre;
    end
  end

  always_comb begin
    state_d  = state_q;
    issue    = CMD_NOP;
    iss_bank = req_bank;
    iss_addr = req_row;
    gap_cyc  = CW'(1);
    wr_load  = 1'b0;
    set_en   = 1'b0;
    clr_en   = 1'b0;
    clr_all  = 1'b0;
    ref_ack  = 1'b0;
    rdy_d    = 1'b0;
    do_act   = 1'b0;
    do_rw    = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (gap_free) begin
          if (ref_pend) begin
            if (any_open) begin
              if (wr_free) begin
                issue    = CMD_PALL;
                iss_bank = '0;
                gap_cyc  = t_pre;
                state_d  = ST_REF;
              end
            end else begin
              issue    = CMD_REF;
              iss_bank = '0;
              gap_cyc  = t_pre;
              clr_all  = 1'b1;
              ref_ack  = 1'b1;
            end
          end else if (req_valid && !req_ready) begin
            if (look_hit) begin
              do_rw = 1'b1;
            end else if (look_open) begin
              if (wr_free) begin
                issue   = CMD_PRE;
                gap_cyc = t_pre;
                clr_en  = 1'b1;
                state_d = ST_ACT;
              end
            end else begin
              do_act = 1'b1;
            end
          end
        end
      end
      ST_ACT: begin
        if (gap_free) do_act = 1'b1;
      end
      ST_RW: begin
        if (gap_free) do_rw = 1'b1;
      end
      ST_REF: begin
        if (gap_free) begin
          issue    = CMD_REF;
          iss_bank = '0;
          gap_cyc  = t_pre;
          clr_all  = 1'b1;
          ref_ack  = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (do_act) begin
      issue    = CMD_ACT;
      iss_addr = req_row;
      gap_cyc  = t_rcd;
      set_en   = cfg_keep_open;
      state_d  = ST_RW;
    end
    if (do_rw) begin
      issue    = rw_cmd;
      iss_addr = ROW_W'(req_col);
      gap_cyc  = rw_gap;
      rdy_d    = 1'b1;
      wr_load  = cfg_keep_open && req_write;
      clr_en   = !cfg_keep_open;
      state_d  = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cmd_q     <= CMD_NOP;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      req_ready <= 1'b0;
    end else begin
      state_q   <= state_d;
      cmd_q     <= issue;
      cmd_bank  <= (issue == CMD_NOP) ? '0 : iss_bank;
      cmd_addr  <= (issue == CMD_NOP) ? '0 : iss_addr;
      req_ready <= rdy_d;
    end
  end

  assign cmd_code = cmd_q;

endmodule

// File: rtl/sdram_row_sequencer_chk.sv
module sdram_row_sequencer_chk
  import sdram_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cfg_keep_open,
  input logic [1:0] cfg_t_pre,
  input logic [1:0] cfg_t_rcd,
  input logic [1:0] cfg_t_wr,
  input logic       req_ready,
  input logic [3:0] cmd_code
);

  // Distances (minus one) since the last command of each kind, saturating.
  logic [3:0] s_pre, s_act, s_wr, s_wra;
  logic is_rw;

  function automatic logic [3:0] bump(input logic [3:0] v);
    return (v == 4'hF) ? v : v + 4'd1;
  endfunction

  assign is_rw = (cmd_code == CMD_RD) || (cmd_code == CMD_WR) ||
                 (cmd_code == CMD_RDA) || (cmd_code == CMD_WRA);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_pre <= 4'hF;
      s_act <= 4'hF;
      s_wr  <= 4'hF;
      s_wra <= 4'hF;
    end else begin
      s_pre <= (cmd_code == CMD_PRE || cmd_code == CMD_PALL) ? 4'd0 : bump(s_pre);
      s_act <= (cmd_code == CMD_ACT) ? 4'd0 : bump(s_act);
      s_wr  <= (cmd_code == CMD_WR)  ? 4'd0 : bump(s_wr);
      s_wra <= (cmd_code == CMD_WRA) ? 4'd0 : bump(s_wra);
    end
  end

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_code <= 4'd8);

  // R7
  pre_to_act_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == CMD_ACT) |-> (s_pre >= {2'b00, cfg_t_pre}));

  // R7
  act_to_rw_chk: assert property (@(posedge clk) disable iff (rst)
    is_rw |-> (s_act >= {2'b00, cfg_t_rcd}));

  // R8
  wra_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_code != CMD_NOP) |-> (s_wra >= ({2'b00, cfg_t_pre} + {2'b00, cfg_t_wr} + 4'd1)));

  // R9
  wr_to_pre_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == CMD_PRE || cmd_code == CMD_PALL) |-> (s_wr >= {2'b00, cfg_t_wr}));

  // R10
  ready_is_rw_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> is_rw);

  // R10
  rw_has_ready_chk: assert property (@(posedge clk) disable iff (rst)
    is_rw |-> req_ready);

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  // R4
  closed_auto_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_keep_open |-> !(cmd_code == CMD_RD || cmd_code == CMD_WR));

  // R5
  open_plain_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_keep_open |-> !(cmd_code == CMD_RDA || cmd_code == CMD_WRA));

endmodule

bind sdram_row_sequencer sdram_row_sequencer_chk chk_i (
  .clk(clk), .rst(rst), .cfg_keep_open(cfg_keep_open),
  .cfg_t_pre(cfg_t_pre), .cfg_t_rcd(cfg_t_rcd), .cfg_t_wr(cfg_t_wr),
  .req_ready(req_ready), .cmd_code(cmd_code)
);

// File: tb/sdram_row_sequencer_test.sv
module sdram_row_sequencer_test;

  localparam int NB = 4, RW = 8, CWID = 6, RFW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_keep_open = 1'b0;
  logic [1:0] cfg_t_pre = '0, cfg_t_rcd = '0, cfg_t_wr = '0;
  logic [RFW-1:0] cfg_ref_interval = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CWID-1:0] req_col = '0;
  logic req_ready;
  logic [3:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [RW-1:0] cmd_addr;

  int total = 0, bad = 0, cyc = 0;
  int lg_n = 0;
  int lg_code [64];
  int lg_cyc  [64];
  int lg_bank [64];
  int lg_addr [64];

  sdram_row_sequencer #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CWID), .REF_W(RFW)) uut (
    .clk(clk), .rst(rst), .cfg_keep_open(cfg_keep_open),
    .cfg_t_pre(cfg_t_pre), .cfg_t_rcd(cfg_t_rcd), .cfg_t_wr(cfg_t_wr),
    .cfg_ref_interval(cfg_ref_interval),
    .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Command monitor: stamps every non-NOP command with its edge count.
  always @(posedge clk) begin
    #1;
    if (!rst && cmd_code != 4'd0 && lg_n < 64) begin
      lg_code[lg_n] = int'(cmd_code);
      lg_cyc[lg_n]  = cyc;
      lg_bank[lg_n] = int'(cmd_bank);
      lg_addr[lg_n] = int'(cmd_addr);
      lg_n = lg_n + 1;
    end
  end

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic apply_reset(input logic ko, input int p, input int r, input int w, input int iv);
    rst = 1'b1;
    req_valid = 1'b0;
    cfg_keep_open = ko;
    cfg_t_pre = 2'(p);
    cfg_t_rcd = 2'(r);
    cfg_t_wr  = 2'(w);
    cfg_ref_interval = RFW'(iv);
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    lg_n = 0;
    chk("R1 cmd_code after reset", int'(cmd_code), 0);
    chk("R1 req_ready after reset", int'(req_ready), 0);
  endtask

  task automatic do_req(input int w, input int b, input int row, input int col);
    bit got;
    got = 1'b0;
    lg_n = 0;
    req_write = w[0];
    req_bank  = 2'(b);
    req_row   = RW'(row);
    req_col   = CWID'(col);
    req_valid = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk);
      #2;
      if (req_ready) begin
        got = 1'b1;
        break;
      end
    end
    if (!got) chk("R10 ready never came", 0, 1);
    req_valid = 1'b0;
  endtask

  task automatic wait_ref(output int c);
    bit found;
    found = 1'b0;
    c = -1;
    lg_n = 0;
    for (int i = 0; i < 400 && !found; i++) begin
      @(posedge clk);
      #2;
      for (int j = 0; j < lg_n; j++) begin
        if (!found && lg_code[j] == 8) begin
          found = 1'b1;
          c = lg_cyc[j];
        end
      end
    end
    if (!found) chk("R11 refresh never issued", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wr_c, r1, r2, r3;
    // Sweep all timing settings in both policies.
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 4; r++) begin
        for (int w = 0; w < 4; w++) begin
          int tp, tr, tw;
          tp = p + 1; tr = r + 1; tw = w + 1;

          apply_reset(1'b1, p, r, w, 0);
          do_req(1, 1, 5, 3);
          chk("R3 closed bank count", lg_n, 2);
          chk("R3 first is ACT", lg_code[0], 1);
          chk("R3 ACT row", lg_addr[0], 5);
          chk("R3 ACT bank", lg_bank[0], 1);
          chk("R5 open policy write code", lg_code[1], 3);
          chk("R3 column on addr", lg_addr[1], 3);
          chk("R7 ACT to column", lg_cyc[1] - lg_cyc[0], tr);
          wr_c = lg_cyc[1];

          do_req(0, 1, 5, 7);
          chk("R5 hit count", lg_n, 1);
          chk("R5 hit read code", lg_code[0], 2);
          chk("R10 hit spacing", lg_cyc[0] - wr_c, 2);

          do_req(1, 1, 5, 9);
          chk("R5 hit write code", lg_code[0], 3);
          wr_c = lg_cyc[0];

          do_req(0, 1, 6, 2);
          chk("R6 miss count", lg_n, 3);
          chk("R6 miss PRE", lg_code[0], 6);
          chk("R6 miss PRE bank", lg_bank[0], 1);
          chk("R6 miss ACT", lg_code[1], 1);
          chk("R6 miss ACT row", lg_addr[1], 6);
          chk("R6 miss read", lg_code[2], 2);
          chk("R9 WR to PRE", lg_cyc[0] - wr_c, mx(2, tw));
          chk("R7 PRE to ACT", lg_cyc[1] - lg_cyc[0], tp);
          chk("R7 ACT to RD", lg_cyc[2] - lg_cyc[1], tr);

          do_req(0, 2, 6, 1);
          chk("R3 other bank count", lg_n, 2);
          chk("R3 other bank ACT", lg_code[0], 1);
          do_req(0, 1, 6, 4);
          chk("R5 per-bank row kept", lg_n, 1);
          chk("R5 per-bank hit code", lg_code[0], 2);

          apply_reset(1'b0, p, r, w, 0);
          do_req(1, 2, 3, 4);
          chk("R4 closed count", lg_n, 2);
          chk("R4 write autoprecharge code", lg_code[1], 5);
          chk("R7 closed ACT to WRA", lg_cyc[1] - lg_cyc[0], tr);
          wr_c = lg_cyc[1];
          do_req(0, 2, 3, 4);
          chk("R4 same row reactivates", lg_code[0], 1);
          chk("R8 WRA hold", lg_cyc[0] - wr_c, tw + tp);
          chk("R4 read autoprecharge code", lg_code[1], 4);
          wr_c = lg_cyc[1];
          do_req(0, 0, 1, 1);
          chk("R8 RDA hold", lg_cyc[0] - wr_c, mx(2, tp));
        end
      end
    end

    // Refresh disabled: bus stays NOP.
    apply_reset(1'b1, 1, 1, 1, 0);
    repeat (100) @(posedge clk);
    #2;
    chk("R11 R14 no command when idle and disabled", lg_n, 0);

    // Refresh with open banks.
    apply_reset(1'b1, 1, 1, 1, 40);
    do_req(1, 0, 7, 1);
    do_req(1, 3, 2, 1);
    wait_ref(r1);
    chk("R12 PALL before REF", lg_code[0], 7);
    chk("R12 REF after PALL", lg_code[1], 8);
    chk("R12 PALL to REF", lg_cyc[1] - lg_cyc[0], 2);
    do_req(0, 0, 7, 1);
    chk("R12 banks closed after refresh", lg_code[0], 1);
    chk("R12 count after refresh", lg_n, 2);

    // Refresh with nothing open, period and priority.
    apply_reset(1'b0, 1, 1, 1, 40);
    wait_ref(r1);
    chk("R12 direct REF count", lg_n, 1);
    chk("R12 direct REF code", lg_code[0], 8);
    wait_ref(r2);
    chk("R11 refresh period", r2 - r1, 40);
    while (cyc < r2 + 39) begin
      @(posedge clk);
      #2;
    end
    do_req(0, 1, 1, 1);
    r3 = lg_cyc[0];
    chk("R13 refresh first", lg_code[0], 8);
    chk("R11 refresh on time", r3, r2 + 40);
    chk("R13 request after refresh", lg_code[1], 1);
    chk("R8 REF to ACT", lg_cyc[1] - lg_cyc[0], 2);
    chk("R4 read after refresh", lg_code[2], 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule